// File: doc/BRIEF.md
# Width-Adapting Register Access Splitter

This block sits between a host bus and a window of peripheral registers whose native widths differ. The host issues byte, halfword or word reads and writes. The block turns each one into the native-width accesses the addressed register expects. An external width map, consulted once per 4-byte address group, gives the native width of the addressed group or marks it as a hole.

A host access wider than the register becomes a run of native accesses at ascending addresses. The most significant part goes first and the results are packed big-endian. A host access narrower than the register reads the containing native register and picks out the wanted lanes. For a write, the block merges the new lanes into the value it read and writes the whole register back. Accesses outside the decoded window, and accesses to holes, finish at once with an error and never reach the downstream port.

Top module: `width_split_bridge`

## Requirements
- R1: Only the low 10 address bits are used, so higher host address bits have no effect. The address is then aligned to the host size by clearing bit 0 for a halfword and bits 1:0 for a word. `req_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word.
- R2: A folded address of 0x200 or above completes with `rsp_err`=1 and `rsp_rdata`=0, and issues no downstream access.
- R3: `map_group` carries folded address bits 8:2, and `map_code` answers 0=hole, 1=8-bit, 2=16-bit, 3=32-bit. A hole completes with `rsp_err`=1 and `rsp_rdata`=0, and issues no downstream access.
- R4: When the host size equals the native width, exactly one downstream access is made at the aligned address. `dn_size` encodes 0=byte, 1=halfword, 2=word, and read and write data are right-aligned on the downstream port.
- R5: A host access wider than the native width N becomes S/N accesses at addresses A, A+N, and so on. The first access carries the most significant part, and the read result is those parts concatenated in that order.
- R6: A host read narrower than the register makes one native read at the register's aligned address. Byte lane L of an N-byte register is taken from bits (N-1-L)*8+7 down to (N-1-L)*8.
- R7: A host write narrower than the register makes one native read and then one native write to the same address. The write changes only the addressed lanes and keeps every other lane as read.
- R8: Exactly one downstream access completes per cycle in which `dn_valid` and `dn_ready` are both high. While `dn_valid` is high and `dn_ready` is low, address, size, direction and write data hold steady.
- R9: `rsp_valid` pulses for one cycle, one cycle after the last downstream handshake or one cycle after an error request is accepted. `req_ready` is low from the acceptance of a downstream-bound request until its response, and write responses carry `rsp_rdata`=0 and `rsp_err`=0.
- R10: After reset `req_ready` is 1, and `dn_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Host byte address |
| req_size | input | 2 | Host access size |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Host write data, right-aligned |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read result, right-aligned |
| rsp_err | output | 1 | Access hit a hole or lay outside the window |
| map_group | output | WIN_BITS-3 | 4-byte group index sent to the width map |
| map_code | input | 2 | Native width code returned by the map |
| dn_valid | output | 1 | Downstream access request |
| dn_ready | input | 1 | Downstream accepts and completes the access this cycle |
| dn_addr | output | WIN_BITS | Downstream byte address |
| dn_size | output | 2 | Downstream access width |
| dn_wr | output | 1 | Downstream write |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid in the handshake cycle |

## Verification
The response pulse of one access and the acceptance of the next host request fall in the same cycle. The register that holds the response is written while the beat state is reloaded. The bench issues every request in the very cycle the previous response is visible, so all several thousand operations run back to back under a pseudo-random downstream stall pattern. It judges each response against a byte-addressed big-endian shadow memory and checks the count and addresses of the downstream accesses for that request. A corrupted merge, a lost response or a stale beat would therefore show in either the data or the access log.

// File: rtl/spl_pkg.sv
package spl_pkg;

    localparam logic [1:0] NW_HOLE = 2'd0;

    // native width code -> bytes
    function automatic logic [2:0] code_bytes(input logic [1:0] c);
        case (c)
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            2'd3:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // host size code (already normalised) -> bytes
    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/spl_classify.sv
module spl_classify
    import spl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 10,
    localparam int GRP_W   = WIN_BITS - 3
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    input  logic                wr,
    input  logic [1:0]          code,
    output logic [GRP_W-1:0]    group,
    output logic                err,
    output logic                rmw,
    output logic [WIN_BITS-1:0] base,
    output logic [1:0]          hsize,
    output logic [1:0]          last,
    output logic [1:0]          lane
);

    logic                unused_hi;
    logic [WIN_BITS-1:0] fa;
    logic [2:0]          nb, sb;
    logic [1:0]          nidx, diff;

    assign unused_hi = ^addr[ADDR_W-1:WIN_BITS];
    assign group     = addr[WIN_BITS-2:2];

    always_comb begin
        hsize = (size == 2'd3) ? 2'd2 : size;
        fa    = addr[WIN_BITS-1:0];
        if (hsize == 2'd1) fa[0]   = 1'b0;
        if (hsize == 2'd2) fa[1:0] = 2'b00;
        nb    = code_bytes(code);
        sb    = size_bytes(hsize);
        err   = fa[WIN_BITS-1] || (code == NW_HOLE);
        rmw   = (code != NW_HOLE) && (sb < nb);
        lane  = fa[1:0] & (nb[1:0] - 2'd1);
        base  = fa;
        if (rmw) base[1:0] = fa[1:0] & ~(nb[1:0] - 2'd1);
        nidx  = code - 2'd1;
        diff  = hsize - nidx;
        if (rmw)                  last = {1'b0, wr};
        else if (code == NW_HOLE) last = 2'd0;
        else begin
            case (diff)
                2'd0:    last = 2'd0;
                2'd1:    last = 2'd1;
                default: last = 2'd3;
            endcase
        end
    end

endmodule

// File: rtl/spl_lanes.sv
module spl_lanes
    import spl_pkg::*;
(
    input  logic [1:0]  ncode,
    input  logic [1:0]  hsize,
    input  logic [1:0]  lane,
    input  logic [1:0]  beat,
    input  logic [1:0]  last,
    input  logic        rmw,
    input  logic [31:0] wdata,
    input  logic [31:0] acc,
    input  logic [31:0] rdata,
    output logic [31:0] wr_data,
    output logic [31:0] acc_nx,
    output logic [31:0] result
);

    logic [2:0]  nb, sb, rb;
    logic [31:0] nmask, smask, rd_n;
    logic [5:0]  nbits, rmw_sh;
    logic [1:0]  steps;
    logic [7:0]  split_sh;

    always_comb begin
        nb       = code_bytes(ncode);
        sb       = size_bytes(hsize);
        nmask    = lane_mask(nb);
        smask    = lane_mask(sb);
        nbits    = {nb, 3'b000};
        steps    = last - beat;
        split_sh = 8'(steps) * 8'(nbits);
        rb       = nb - sb - {1'b0, lane};
        rmw_sh   = {rb, 3'b000};
        rd_n     = rdata & nmask;
        if (rmw) begin
            wr_data = (acc & ~(smask << rmw_sh)) | ((wdata & smask) << rmw_sh);
            acc_nx  = rd_n;
            result  = (acc_nx >> rmw_sh) & smask;
        end else begin
            wr_data = (wdata >> split_sh) & nmask;
            acc_nx  = (nb == 3'd4) ? rd_n : ((acc << nbits) | rd_n);
            result  = acc_nx;
        end
    end

endmodule

// File: rtl/width_split_bridge.sv
module width_split_bridge
    import spl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 10,
    localparam int GRP_W   = WIN_BITS - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_wr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_err,
    output logic [GRP_W-1:0]    map_group,
    input  logic [1:0]          map_code,
    output logic                dn_valid,
    input  logic                dn_ready,
    output logic [WIN_BITS-1:0] dn_addr,
    output logic [1:0]          dn_size,
    output logic                dn_wr,
    output logic [31:0]         dn_wdata,
    input  logic [31:0]         dn_rdata
);

    typedef struct packed {
        logic                busy;
        logic                rmw;
        logic                wr;
        logic [WIN_BITS-1:0] base;
        logic [1:0]          hsize;
        logic [1:0]          ncode;
        logic [1:0]          lane;
        logic [1:0]          beat;
        logic [1:0]          last;
        logic [31:0]         wdata;
        logic [31:0]         acc;
        logic                rsp_v;
        logic                rsp_e;
        logic [31:0]         rsp_d;
    } st_t;

    st_t st_q, st_d;

    logic                c_err, c_rmw;
    logic [WIN_BITS-1:0] c_base;
    logic [1:0]          c_hsize, c_last, c_lane;
    logic [31:0]         l_wdata, l_acc_nx, l_result;

    spl_classify #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) classify_i (
        .addr  (req_addr),
        .size  (req_size),
        .wr    (req_wr),
        .code  (map_code),
        .group (map_group),
        .err   (c_err),
        .rmw   (c_rmw),
        .base  (c_base),
        .hsize (c_hsize),
        .last  (c_last),
        .lane  (c_lane)
    );

    spl_lanes lanes_i (
        .ncode   (st_q.ncode),
        .hsize   (st_q.hsize),
        .lane    (st_q.lane),
        .beat    (st_q.beat),
        .last    (st_q.last),
        .rmw     (st_q.rmw),
        .wdata   (st_q.wdata),
        .acc     (st_q.acc),
        .rdata   (dn_rdata),
        .wr_data (l_wdata),
        .acc_nx  (l_acc_nx),
        .result  (l_result)
    );

    // downstream port driven from the registered beat state
    assign req_ready = !st_q.busy;
    assign dn_valid  = st_q.busy;
    assign dn_size   = st_q.ncode - 2'd1;
    assign dn_wr     = st_q.rmw ? (st_q.beat == 2'd1) : st_q.wr;
    assign dn_wdata  = l_wdata;
    assign dn_addr   = st_q.base +
                       (st_q.rmw ? '0 : (WIN_BITS'(st_q.beat) << (st_q.ncode - 2'd1)));
    assign rsp_valid = st_q.rsp_v;
    assign rsp_err   = st_q.rsp_e;
    assign rsp_rdata = st_q.rsp_d;

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        st_d.rsp_e = 1'b0;
        st_d.rsp_d = '0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (c_err) begin
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_e = 1'b1;
                end else begin
                    st_d.busy  = 1'b1;
                    st_d.rmw   = c_rmw;
                    st_d.wr    = req_wr;
                    st_d.base  = c_base;
                    st_d.hsize = c_hsize;
                    st_d.ncode = map_code;
                    st_d.lane  = c_lane;
                    st_d.beat  = 2'd0;
                    st_d.last  = c_last;
                    st_d.wdata = req_wdata;
                    st_d.acc   = '0;
                end
            end
        end else if (dn_ready) begin
            if (!(st_q.rmw && st_q.beat == 2'd1)) st_d.acc = l_acc_nx;
            if (st_q.beat == st_q.last) begin
                st_d.busy  = 1'b0;
                st_d.rsp_v = 1'b1;
                st_d.rsp_d = st_q.wr ? 32'h0 : l_result;
            end else begin
                st_d.beat = st_q.beat + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a stalled downstream access keeps every field steady
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_size)
                                  && $stable(dn_wr) && $stable(dn_wdata));

    // R2: nothing at or above the window limit reaches downstream
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !dn_addr[WIN_BITS-1]);

    // R3: rejected request answers next cycle without downstream traffic
    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_addr[WIN_BITS-1] || map_code == NW_HOLE)
        |=> rsp_valid && rsp_err && !dn_valid);

    // R9: error responses carry zero data
    p_errzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == 32'h0);

    // R9: host side closed while a downstream access is outstanding
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !req_ready && !rsp_valid);

    // R4: downstream size code never takes the unused value
    p_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_size != 2'd3);

endmodule

// File: tb/width_split_bridge_tb.sv
`timescale 1ns/1ps
module width_split_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [6:0]  map_group;
    logic [1:0]  map_code;
    logic        dn_valid;
    logic        dn_ready = 1'b1;
    logic [9:0]  dn_addr;
    logic [1:0]  dn_size;
    logic        dn_wr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata;

    int errors = 0;
    int checks = 0;
    int total_cnt = 0;
    logic [9:0]  log_addr [0:7];
    logic [7:0]  dmem [0:1023];
    logic [7:0]  rmem [0:1023];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    width_split_bridge #(.ADDR_W(16), .WIN_BITS(10)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .map_group(map_group), .map_code(map_code),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_size(dn_size), .dn_wr(dn_wr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    function automatic logic [1:0] tab(input int g);
        if (g % 5 == 4) return 2'd0;
        return 2'((g % 3) + 1);
    endfunction

    assign map_code = tab(int'(map_group));

    always_comb begin
        case (dn_size)
            2'd0:    dn_rdata = {24'h0, dmem[int'(dn_addr)]};
            2'd1:    dn_rdata = {16'h0, dmem[int'(dn_addr)], dmem[int'(dn_addr)+1]};
            default: dn_rdata = {dmem[int'(dn_addr)], dmem[int'(dn_addr)+1],
                                 dmem[int'(dn_addr)+2], dmem[int'(dn_addr)+3]};
        endcase
    end

    // downstream register model and access log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) dmem[i] <= 8'(i * 37 + 5);
        end else if (dn_valid && dn_ready) begin
            total_cnt <= total_cnt + 1;
            log_addr[total_cnt % 8] <= dn_addr;
            if (dn_wr) begin
                case (dn_size)
                    2'd0: dmem[int'(dn_addr)] <= dn_wdata[7:0];
                    2'd1: begin
                        dmem[int'(dn_addr)]   <= dn_wdata[15:8];
                        dmem[int'(dn_addr)+1] <= dn_wdata[7:0];
                    end
                    default: begin
                        dmem[int'(dn_addr)]   <= dn_wdata[31:24];
                        dmem[int'(dn_addr)+1] <= dn_wdata[23:16];
                        dmem[int'(dn_addr)+2] <= dn_wdata[15:8];
                        dmem[int'(dn_addr)+3] <= dn_wdata[7:0];
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dn_ready <= lfsr[0] | lfsr[3];
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // caller sits at a negedge; the request goes out at once
    task automatic do_op(input logic [15:0] a, input int sz, input logic w,
                         input logic [31:0] wd, input string force_tag);
        logic [9:0]  fa;
        logic [31:0] ed;
        logic [1:0]  code;
        logic        e;
        logic        addr_ok;
        int          s_b, n_b, ecnt, start, waitc;
        string       tag;
        fa = a[9:0];
        if (sz == 1) fa[0] = 1'b0;
        if (sz >= 2) fa[1:0] = 2'b00;
        s_b  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        code = tab(int'(fa[8:2]));
        n_b  = (code == 2'd1) ? 1 : (code == 2'd2) ? 2 : (code == 2'd3) ? 4 : 0;
        e    = fa[9] || (n_b == 0);
        if (fa[9])           tag = "R2";
        else if (n_b == 0)   tag = "R3";
        else if (s_b == n_b) tag = "R4";
        else if (s_b > n_b)  tag = "R5";
        else if (w)          tag = "R7";
        else                 tag = "R6";
        if (force_tag != "") tag = force_tag;
        ed = '0;
        if (!e && !w)
            for (int k = 0; k < s_b; k++) ed = (ed << 8) | 32'(rmem[int'(fa) + k]);
        ecnt  = e ? 0 : (s_b >= n_b) ? s_b / n_b : (w ? 2 : 1);
        start = total_cnt;

        req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_wr = w; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!e) chk(req_ready == 1'b0, "R9", "ready low while busy", 32'(req_ready), 32'h0);
        waitc = 0;
        while (!rsp_valid && waitc < 100) begin
            @(negedge clk);
            waitc++;
        end
        chk(rsp_valid && rsp_rdata == ed && rsp_err == e, tag, "response data/err",
            rsp_rdata ^ {31'h0, rsp_err}, ed ^ {31'h0, e});
        chk(total_cnt - start == ecnt, "R8", "downstream access count",
            32'(total_cnt - start), 32'(ecnt));
        addr_ok = 1'b1;
        for (int k = 0; k < ecnt; k++) begin
            if (s_b >= n_b) addr_ok &= (log_addr[(start + k) % 8] == fa + 10'(k * n_b));
            else addr_ok &= (log_addr[(start + k) % 8] == (fa & ~10'(n_b - 1)));
        end
        chk(addr_ok, tag, "downstream address order", 32'(log_addr[start % 8]), 32'(fa));
        if (!e && w)
            for (int k = 0; k < s_b; k++) rmem[int'(fa) + k] = wd[(s_b - 1 - k) * 8 +: 8];
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) rmem[i] = 8'(i * 37 + 5);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: idle after reset
        chk(req_ready == 1'b1 && dn_valid == 1'b0 && rsp_valid == 1'b0, "R10",
            "reset state", {29'h0, req_ready, dn_valid, rsp_valid}, 32'h4);

        for (int a = 0; a < 512; a++)
            for (int sz = 0; sz < 3; sz++) do_op(16'(a), sz, 1'b0, 32'h0, "");
        for (int a = 0; a < 512; a++)
            do_op(16'(a), a % 3, 1'b1, 32'(a) * 32'h9E37_79B1 ^ 32'h5A5A_C3C3, "");
        for (int a = 0; a < 512; a++) do_op(16'(a), 0, 1'b0, 32'h0, "");
        for (int a = 0; a < 512; a += 4) do_op(16'(a), 2, 1'b0, 32'h0, "");
        for (int a = 512; a < 1024; a += 29)
            for (int sz = 0; sz < 3; sz++) begin
                do_op(16'(a), sz, 1'b1, 32'hDEAD_BEEF, "R2");
                do_op(16'(a), sz, 1'b0, 32'h0, "R2");
            end
        for (int a = 0; a < 512; a += 4) do_op(16'(a), 2, 1'b0, 32'h0, "");
        // R1: upper address bits and low misalignment are ignored
        for (int a = 0; a < 64; a++) begin
            do_op(16'hA400 | 16'(a * 7 % 512), a % 3, 1'b1, 32'(a) * 32'h0101_0103, "R1");
            do_op(16'hFC00 | 16'(a * 7 % 512), (a + 1) % 3, 1'b0, 32'h0, "R1");
        end
        for (int a = 0; a < 512; a += 4) do_op(16'(a), 2, 1'b0, 32'h0, "");
        summary();
        $finish;
    end

endmodule